// File: doc/BRIEF.md
# Bus Address Translation Window Unit

This block holds a small set of programmable address windows that remap addresses travelling between a processor-side address space and a PCI-side address space. Four windows serve the outbound direction (processor to PCI) and three serve the inbound direction (PCI to processor). Software sets them up through a 32-bit register port that decodes a 4 KB control region. One additional 32-bit register holds a gasket timer value and is plain storage only.

Each direction has its own combinational lookup port. The port takes a 64-bit address and returns three things: a hit flag, the index of the matching window, and the translated address. A window is described by a page-granular base, a page-granular target and an attribute word. The attribute word carries an enable bit and a power-of-two size exponent.

The design has no sequencing state machine. The only sequential state is the register file, which has two conditions: reset (every register zero) and programmed. A write moves the register file from one programmed state to the next. Lookups always reflect the register contents of the current cycle.

Top module: `xlat_win_unit`

## Requirements
- R1: After reset every register reads 0, every window is disabled, and both lookup ports report a miss.
- R2: Outbound window w (w = 0..3) occupies the 32-byte group at 0xC20 + 0x20*w. Within it: target page at +0x00, extended target at +0x04, base page at +0x08, attribute at +0x10. Each of these reads back the last value written to it.
- R3: Inbound window v (v = 0..2) occupies the group at 0xDA0 + 0x20*v, so 0xDA0 is v=0 and 0xDE0 is v=2. Within it: target page at +0x00, base page at +0x08, extended base at +0x0C, attribute at +0x10. Each reads back the last value written to it.
- R4: Offset 0xE20 is a 32-bit read/write register with no effect on any lookup.
- R5: Every other offset inside the 4 KB region reads 0. A write to such an offset changes no register and no lookup result. This includes offsets below 0xC00, unused offsets within a group, and addresses that are not word aligned.
- R6: Attribute bit 31 enables a window. A window whose bit 31 is 0 never hits.
- R7: A window's base address is the base page value shifted left by 12. Its size is 2 << attribute[5:0] bytes. An address hits when base <= address < base + size. An exponent of 63 covers the whole 64-bit space.
- R8: On a hit, the translated address is (target page << 12) + (address - base), taken modulo 2^64.
- R9: When several enabled windows in one direction contain the address, the window with the lowest index is reported.
- R10: On a miss, the hit flag is 0, the index is 0 and the translated address equals the input address.
- R11: A register write on a clock edge changes the lookup result from that edge on. Before the edge, the lookup shows the old mapping.
- R12: The extended target (outbound) and extended base (inbound) registers are storage only and do not alter translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset within the control region |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ob_addr | input | 64 | Outbound lookup address |
| ob_hit | output | 1 | Outbound window matched |
| ob_idx | output | 2 | Index of the matching outbound window |
| ob_xlat | output | 64 | Translated outbound address |
| ib_addr | input | 64 | Inbound lookup address |
| ib_hit | output | 1 | Inbound window matched |
| ib_idx | output | 2 | Index of the matching inbound window |
| ib_xlat | output | 64 | Translated inbound address |

## Verification
Assertions check four properties on every cycle. A miss always passes the address through with index 0. A reported hit always names an enabled window whose base lies at or below the address. A write to the timer register lands on the next edge. A write to an undecoded offset leaves every mapping and the timer unchanged.

Only the bench scenarios can show the rest. These are the exact translated values, the upper size boundaries, the priority between overlapping windows, the full-space window with address wrap, the register offset layout of each direction, and the one-edge timing of a remapping write.

// File: rtl/xlat_win_pkg.sv
package xlat_win_pkg;
    localparam int NUM_OB    = 4;
    localparam int NUM_IB    = 3;
    localparam int ADDR_W    = 64;
    localparam int REG_W     = 32;
    localparam int CSR_AW    = 12;
    localparam int PAGE_SH   = 12;
    localparam int OB_IDX_W  = (NUM_OB > 1) ? $clog2(NUM_OB) : 1;
    localparam int IB_IDX_W  = (NUM_IB > 1) ? $clog2(NUM_IB) : 1;
    localparam int ATTR_EN   = 31;
    localparam int EXP_W     = 6;

    // 32-byte group numbers (address bits [11:5])
    localparam logic [6:0] OB_GRP0    = 7'h61;
    localparam logic [6:0] IB_GRP0    = 7'h6D;
    localparam logic [6:0] GASKET_GRP = 7'h71;

    // field offsets inside a group
    localparam logic [4:0] OFF_TGT   = 5'h00;
    localparam logic [4:0] OFF_OEXT  = 5'h04;
    localparam logic [4:0] OFF_BASE  = 5'h08;
    localparam logic [4:0] OFF_IEXT  = 5'h0C;
    localparam logic [4:0] OFF_ATTR  = 5'h10;

    typedef struct packed {
        logic              en;
        logic [EXP_W-1:0]  sz_exp;
        logic [REG_W-1:0]  base_pg;
        logic [REG_W-1:0]  tgt_pg;
    } win_map_t;

    function automatic logic [ADDR_W-1:0] pg2addr(input logic [REG_W-1:0] pg);
        return {{(ADDR_W-REG_W-PAGE_SH){1'b0}}, pg, {PAGE_SH{1'b0}}};
    endfunction
endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs
    import xlat_win_pkg::*;
#(
    parameter int N_OB = NUM_OB,
    parameter int N_IB = NUM_IB
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [CSR_AW-1:0]           reg_addr,
    input  logic [REG_W-1:0]            reg_wdata,
    output logic [REG_W-1:0]            reg_rdata,
    output win_map_t [N_OB-1:0]         ob_map_o,
    output win_map_t [N_IB-1:0]         ib_map_o
);
    localparam int OIW = (N_OB > 1) ? $clog2(N_OB) : 1;
    localparam int IIW = (N_IB > 1) ? $clog2(N_IB) : 1;

    logic [6:0] grp;
    logic [4:0] off;
    logic [6:0] ob_sel, ib_sel;
    logic       ob_in, ib_in, gas_hit;
    logic       ob_fld_ok, ib_fld_ok, wr_known;
    logic [REG_W-1:0] gasket_q;

    logic [N_OB-1:0][REG_W-1:0] ob_tgt_v, ob_ext_v, ob_base_v, ob_attr_v;
    logic [N_IB-1:0][REG_W-1:0] ib_tgt_v, ib_ext_v, ib_base_v, ib_attr_v;

    assign grp    = reg_addr[11:5];
    assign off    = reg_addr[4:0];
    assign ob_sel = grp - OB_GRP0;
    assign ib_sel = grp - IB_GRP0;
    assign ob_in  = (grp >= OB_GRP0) && (ob_sel < 7'(N_OB));
    assign ib_in  = (grp >= IB_GRP0) && (ib_sel < 7'(N_IB));
    assign gas_hit = (grp == GASKET_GRP) && (off == 5'h00);
    assign ob_fld_ok = (off == OFF_TGT) || (off == OFF_OEXT) ||
                       (off == OFF_BASE) || (off == OFF_ATTR);
    assign ib_fld_ok = (off == OFF_TGT) || (off == OFF_IEXT) ||
                       (off == OFF_BASE) || (off == OFF_ATTR);
    assign wr_known = (ob_in && ob_fld_ok) || (ib_in && ib_fld_ok) || gas_hit;

    // outbound windows
    for (genvar w = 0; w < N_OB; w++) begin : g_ob
        logic [REG_W-1:0] tgt_q, ext_q, base_q, attr_q;
        logic             sel;
        assign sel = reg_we && ob_in && (ob_sel == 7'(w));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tgt_q  <= '0;
                ext_q  <= '0;
                base_q <= '0;
                attr_q <= '0;
            end else if (sel) begin
                unique case (off)
                    OFF_TGT:  tgt_q  <= reg_wdata;
                    OFF_OEXT: ext_q  <= reg_wdata;
                    OFF_BASE: base_q <= reg_wdata;
                    OFF_ATTR: attr_q <= reg_wdata;
                    default:  ;
                endcase
            end
        end
        assign ob_tgt_v[w]  = tgt_q;
        assign ob_ext_v[w]  = ext_q;
        assign ob_base_v[w] = base_q;
        assign ob_attr_v[w] = attr_q;
        assign ob_map_o[w]  = '{en: attr_q[ATTR_EN], sz_exp: attr_q[EXP_W-1:0],
                                base_pg: base_q, tgt_pg: tgt_q};
    end

    // inbound windows
    for (genvar v = 0; v < N_IB; v++) begin : g_ib
        logic [REG_W-1:0] tgt_q, ext_q, base_q, attr_q;
        logic             sel;
        assign sel = reg_we && ib_in && (ib_sel == 7'(v));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tgt_q  <= '0;
                ext_q  <= '0;
                base_q <= '0;
                attr_q <= '0;
            end else if (sel) begin
                unique case (off)
                    OFF_TGT:  tgt_q  <= reg_wdata;
                    OFF_IEXT: ext_q  <= reg_wdata;
                    OFF_BASE: base_q <= reg_wdata;
                    OFF_ATTR: attr_q <= reg_wdata;
                    default:  ;
                endcase
            end
        end
        assign ib_tgt_v[v]  = tgt_q;
        assign ib_ext_v[v]  = ext_q;
        assign ib_base_v[v] = base_q;
        assign ib_attr_v[v] = attr_q;
        assign ib_map_o[v]  = '{en: attr_q[ATTR_EN], sz_exp: attr_q[EXP_W-1:0],
                                base_pg: base_q, tgt_pg: tgt_q};
    end

    // timer storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gasket_q <= '0;
        else if (reg_we && gas_hit)
            gasket_q <= reg_wdata;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (ob_in) begin
            unique case (off)
                OFF_TGT:  reg_rdata = ob_tgt_v[ob_sel[OIW-1:0]];
                OFF_OEXT: reg_rdata = ob_ext_v[ob_sel[OIW-1:0]];
                OFF_BASE: reg_rdata = ob_base_v[ob_sel[OIW-1:0]];
                OFF_ATTR: reg_rdata = ob_attr_v[ob_sel[OIW-1:0]];
                default:  reg_rdata = '0;
            endcase
        end else if (ib_in) begin
            unique case (off)
                OFF_TGT:  reg_rdata = ib_tgt_v[ib_sel[IIW-1:0]];
                OFF_IEXT: reg_rdata = ib_ext_v[ib_sel[IIW-1:0]];
                OFF_BASE: reg_rdata = ib_base_v[ib_sel[IIW-1:0]];
                OFF_ATTR: reg_rdata = ib_attr_v[ib_sel[IIW-1:0]];
                default:  reg_rdata = '0;
            endcase
        end else if (gas_hit) begin
            reg_rdata = gasket_q;
        end
    end

    // R4: timer write lands on the next edge
    a_r4_timer_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && gas_hit) |=> (gasket_q == $past(reg_wdata)));

    // R5: undecoded write changes nothing
    a_r5_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !wr_known) |=> ($stable(ob_map_o) && $stable(ib_map_o) && $stable(gasket_q)));
endmodule

// File: rtl/xlat_win_match.sv
module xlat_win_match
    import xlat_win_pkg::*;
(
    input  win_map_t            map_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                hit_o,
    output logic [ADDR_W-1:0]   xlat_o
);
    logic [ADDR_W-1:0] base_a, tgt_a;
    logic [ADDR_W:0]   size_w, limit_w;

    assign base_a  = pg2addr(map_i.base_pg);
    assign tgt_a   = pg2addr(map_i.tgt_pg);
    assign size_w  = (ADDR_W+1)'(2) << map_i.sz_exp;
    assign limit_w = {1'b0, base_a} + size_w;
    assign hit_o   = map_i.en && (addr_i >= base_a) && ({1'b0, addr_i} < limit_w);
    assign xlat_o  = tgt_a + (addr_i - base_a);
endmodule

// File: rtl/xlat_win_lookup.sv
module xlat_win_lookup
    import xlat_win_pkg::*;
#(
    parameter int N    = 4,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  win_map_t [N-1:0]     map_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 hit_o,
    output logic [IDXW-1:0]      idx_o,
    output logic [ADDR_W-1:0]    xlat_o
);
    logic [N-1:0]              hit_v;
    logic [N-1:0][ADDR_W-1:0]  xl_v;

    for (genvar i = 0; i < N; i++) begin : g_win
        xlat_win_match u_match (
            .map_i  (map_i[i]),
            .addr_i (addr_i),
            .hit_o  (hit_v[i]),
            .xlat_o (xl_v[i])
        );
    end

    // lowest index wins: scan from the top so lower indices override
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        xlat_o = addr_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                hit_o  = 1'b1;
                idx_o  = IDXW'(i);
                xlat_o = xl_v[i];
            end
        end
    end

    // R10: miss passes address through with index 0
    a_r10_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (xlat_o == addr_i && idx_o == '0));

    // R6: a hit names an enabled window
    a_r6_hit_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> map_i[idx_o].en);

    // R7: a hit never lies below the window base
    a_r7_hit_above_base: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (addr_i >= pg2addr(map_i[idx_o].base_pg)));
endmodule

// File: rtl/xlat_win_unit.sv
module xlat_win_unit
    import xlat_win_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [11:0]          reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [63:0]          ob_addr,
    output logic                 ob_hit,
    output logic [1:0]           ob_idx,
    output logic [63:0]          ob_xlat,
    input  logic [63:0]          ib_addr,
    output logic                 ib_hit,
    output logic [1:0]           ib_idx,
    output logic [63:0]          ib_xlat
);
    win_map_t [NUM_OB-1:0] ob_map;
    win_map_t [NUM_IB-1:0] ib_map;

    xlat_win_regs #(.N_OB(NUM_OB), .N_IB(NUM_IB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ob_map_o  (ob_map),
        .ib_map_o  (ib_map)
    );

    xlat_win_lookup #(.N(NUM_OB), .IDXW(OB_IDX_W)) u_ob (
        .clk    (clk),
        .rst_n  (rst_n),
        .map_i  (ob_map),
        .addr_i (ob_addr),
        .hit_o  (ob_hit),
        .idx_o  (ob_idx),
        .xlat_o (ob_xlat)
    );

    xlat_win_lookup #(.N(NUM_IB), .IDXW(IB_IDX_W)) u_ib (
        .clk    (clk),
        .rst_n  (rst_n),
        .map_i  (ib_map),
        .addr_i (ib_addr),
        .hit_o  (ib_hit),
        .idx_o  (ib_idx),
        .xlat_o (ib_xlat)
    );
endmodule

// File: tb/tb_xlat_win_unit.sv
`timescale 1ns/1ps
module tb_xlat_win_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] ob_addr = '0, ib_addr = '0;
    logic        ob_hit, ib_hit;
    logic [1:0]  ob_idx, ib_idx;
    logic [63:0] ob_xlat, ib_xlat;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    xlat_win_unit dut (.*);

    typedef struct packed {
        logic        dir;   // 0 outbound, 1 inbound
        logic [63:0] a;
        logic        hit;
        logic [1:0]  idx;
        logic [63:0] x;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h10010,       1'b1, 2'd0, 64'h80010},
        '{1'b0, 64'h10FFF,       1'b1, 2'd0, 64'h80FFF},
        '{1'b0, 64'h11000,       1'b1, 2'd1, 64'h201000},
        '{1'b0, 64'h1FFFF,       1'b1, 2'd1, 64'h20FFFF},
        '{1'b0, 64'h20000,       1'b0, 2'd0, 64'h20000},
        '{1'b0, 64'hFFFF,        1'b0, 2'd0, 64'hFFFF},
        '{1'b0, 64'h30000,       1'b0, 2'd0, 64'h30000},
        '{1'b0, 64'h100000000,   1'b1, 2'd3, 64'h1000},
        '{1'b0, 64'h1000FFFFF,   1'b1, 2'd3, 64'h100FFF},
        '{1'b0, 64'h100100000,   1'b0, 2'd0, 64'h100100000},
        '{1'b1, 64'h0,           1'b1, 2'd0, 64'h400000},
        '{1'b1, 64'hFFF,         1'b1, 2'd0, 64'h400FFF},
        '{1'b1, 64'h1000,        1'b1, 2'd2, 64'h501000},
        '{1'b1, 64'h1FFF,        1'b1, 2'd2, 64'h501FFF},
        '{1'b1, 64'h2000,        1'b0, 2'd0, 64'h2000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic look(input logic dir, input logic [63:0] a);
        @(negedge clk);
        if (dir) ib_addr = a; else ob_addr = a;
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(12'hC30, rv); chk("R1 attr reset", 64'(rv), 64'h0);
        rd(12'hE20, rv); chk("R1 timer reset", 64'(rv), 64'h0);
        look(1'b0, 64'h0); chk("R1 ob miss", 64'(ob_hit), 64'h0);
        look(1'b1, 64'h0); chk("R1 ib miss", 64'(ib_hit), 64'h0);

        // program windows (R2, R3)
        wr(12'hC28, 32'h10);    wr(12'hC20, 32'h80);  wr(12'hC30, 32'h8000000B);
        wr(12'hC48, 32'h10);    wr(12'hC40, 32'h200); wr(12'hC50, 32'h8000000F);
        wr(12'hC68, 32'h30);    wr(12'hC60, 32'h900); wr(12'hC70, 32'h0000000B);
        wr(12'hC88, 32'h00100000); wr(12'hC80, 32'h1); wr(12'hC90, 32'h80000013);
        wr(12'hDA8, 32'h0);     wr(12'hDA0, 32'h400); wr(12'hDB0, 32'h8000000B);
        wr(12'hDE8, 32'h0);     wr(12'hDE0, 32'h500); wr(12'hDF0, 32'h8000000C);

        // vector table: R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            look(VECS[i].dir, VECS[i].a);
            if (VECS[i].dir) begin
                chk("R7/R10 ib hit", 64'(ib_hit), 64'(VECS[i].hit));
                chk("R9 ib idx", 64'(ib_idx), 64'(VECS[i].idx));
                chk("R8 ib xlat", ib_xlat, VECS[i].x);
            end else begin
                chk("R6/R7 ob hit", 64'(ob_hit), 64'(VECS[i].hit));
                chk("R9 ob idx", 64'(ob_idx), 64'(VECS[i].idx));
                chk("R8 ob xlat", ob_xlat, VECS[i].x);
            end
        end

        // R2 readback
        rd(12'hC28, rv); chk("R2 ob base rb", 64'(rv), 64'h10);
        rd(12'hC90, rv); chk("R2 ob attr rb", 64'(rv), 64'h80000013);
        // R3 readback and index order
        rd(12'hDA0, rv); chk("R3 ib0 tgt rb", 64'(rv), 64'h400);
        rd(12'hDE0, rv); chk("R3 ib2 tgt rb", 64'(rv), 64'h500);
        rd(12'hDC0, rv); chk("R3 ib1 untouched", 64'(rv), 64'h0);

        // R12 extended registers are storage only
        wr(12'hC24, 32'hABCD);
        rd(12'hC24, rv); chk("R12 ob ext rb", 64'(rv), 64'hABCD);
        wr(12'hDEC, 32'h77);
        rd(12'hDEC, rv); chk("R12 ib ext rb", 64'(rv), 64'h77);
        look(1'b0, 64'h10010); chk("R12 ob xlat kept", ob_xlat, 64'h80010);
        look(1'b1, 64'h1000);  chk("R12 ib xlat kept", ib_xlat, 64'h501000);

        // R4 timer storage
        wr(12'hE20, 32'h12345678);
        rd(12'hE20, rv); chk("R4 timer rb", 64'(rv), 64'h12345678);
        look(1'b0, 64'h11000); chk("R4 ob unchanged", ob_xlat, 64'h201000);

        // R5 undecoded offsets
        wr(12'hDA4, 32'hFFFFFFFF);
        rd(12'hDA4, rv); chk("R5 ib gap reads 0", 64'(rv), 64'h0);
        wr(12'hC2C, 32'hFFFFFFFF);
        rd(12'hC2C, rv); chk("R5 ob gap reads 0", 64'(rv), 64'h0);
        wr(12'hC31, 32'h0);
        rd(12'hC30, rv); chk("R5 misaligned ignored", 64'(rv), 64'h8000000B);
        rd(12'h000, rv); chk("R5 low region 0", 64'(rv), 64'h0);
        look(1'b1, 64'h0); chk("R5 ib xlat kept", ib_xlat, 64'h400000);
        look(1'b0, 64'h10010); chk("R5 ob xlat kept", ob_xlat, 64'h80010);

        // R11 write effective from the edge it lands on (disable ob0)
        @(negedge clk);
        reg_we = 1; reg_addr = 12'hC30; reg_wdata = 32'h0000000B;
        ob_addr = 64'h10010;
        #1 chk("R11 before edge", ob_xlat, 64'h80010);
        @(negedge clk);
        reg_we = 0;
        #1 chk("R11 after edge idx", 64'(ob_idx), 64'h1);
        chk("R11 after edge xlat", ob_xlat, 64'h200010);

        // R7 full-space window with wrap (ob2, exponent 63)
        wr(12'hC68, 32'h0);
        wr(12'hC70, 32'h8000003F);
        look(1'b0, 64'h500000000);
        chk("R7 full idx", 64'(ob_idx), 64'h2);
        chk("R7 full xlat", ob_xlat, 64'h500900000);
        look(1'b0, 64'hFFFFFFFFFFFFFFFF);
        chk("R8 wrap xlat", ob_xlat, 64'h8FFFFF);
        look(1'b0, 64'h10010);
        chk("R9 ob1 over ob2", 64'(ob_idx), 64'h1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule